// File: doc/BRIEF.md
# Sparse-Space Address Translator

This block converts a 40-bit processor address aimed at one of the uncached sparse windows into a 32-bit PCI address and a set of active-low byte enables. In sparse addressing, the processor does not carry byte-enable sidebands. Instead, the access size and the starting byte lane are folded into the low processor address bits. The processor-side offset is five bits wider than the PCI offset. The translator finds the target window from the upper address bits. It turns the size and lane code into byte enables and shifts the quadword offset down to PCI granularity.

The PCI address bits above a memory window's offset width come from a small high-address extension register. Software writes this register through a one-field CSR write port. The I/O window has no extension and drives those bits to zero.

Each accepted request produces one registered result carrying the PCI address, the byte enables, a code that names the window, and an error flag. Malformed or unmapped requests raise the error flag. They do not stall the block.

Top module: `sparse_xlate_top`

## Requirements
- R1: A result (`res_valid` high) appears exactly one clock after a cycle with `req_valid` high, and `res_valid` is low one clock after a cycle with `req_valid` low; `res_write` repeats that request's `req_write`.
- R2: The window is chosen by address range and reported on `res_space`. Memory window A spans 0x80_0000_0000..0x83_FFFF_FFFF (code 1). Memory window B spans 0x84_0000_0000..0x84_FFFF_FFFF (code 2). Memory window C spans 0x85_0000_0000..0x85_7FFF_FFFF (code 3). The I/O window spans 0x85_8000_0000..0x85_BFFF_FFFF (code 4).
- R3: Address bits 4:3 give the size (00 one byte, 01 two, 10 three, 11 four bytes), and bits 6:5 give the first byte lane. A one-byte access at lanes 0..3 yields `res_be` 1110, 1101, 1011 and 0111.
- R4: A two-byte access yields 1100, 1001 and 0011 at lanes 0, 1 and 2. A three-byte access yields 1000 at lane 0 and 0001 at lane 1. A four-byte access at lane 0 yields 0000.
- R5: A size and lane pair whose bytes run past lane 3 sets `res_err`, drives `res_be` to 1111 and `res_addr` to 0, and still reports the window code.
- R6: A request with any of address bits 2:0 set is flagged with `res_err`, `res_be` 1111 and `res_addr` 0.
- R7: An address outside all four windows, including any with bit 39 clear, gives `res_err` high, `res_space` 0, `res_be` 1111 and `res_addr` 0.
- R8: For a good request, with W the window's PCI offset width (A 29, B 27, C 26, I/O 25), `res_addr[W-1:2]` equals processor address bits W+4..7 taken relative to the window base, and `res_addr[1:0]` is 00.
- R9: For the memory windows, `res_addr[31:W]` equals the matching bits of the extension register. `csr_wdata` bits 5:0 hold PCI address bits 31:26. For the I/O window these bits are zero. After reset the register holds zero.
- R10: A CSR write is used by requests presented from the following cycle on. A request in the same cycle as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request direction, 1 for write |
| req_addr | input | 40 | Processor address |
| csr_we | input | 1 | Extension register write strobe |
| csr_wdata | input | 6 | New PCI address bits 31:26 |
| res_valid | output | 1 | Result strobe |
| res_write | output | 1 | Direction of the translated request |
| res_addr | output | 32 | PCI address |
| res_be | output | 4 | Active-low byte enables |
| res_space | output | 3 | Window code, 0 for none |
| res_err | output | 1 | Malformed or unmapped request |

## Verification
Every translated field is due on the clock edge right after the request cycle. The bench drives inputs on the falling edge and compares on the next falling edge, so each comparison lands half a period after the edge that loaded the result. A CSR write changes only requests issued after the write's edge. The reference model therefore updates its copy of the register after computing the expectation for a request in the same cycle. This is how the same-cycle and next-cycle cases are told apart.

// File: rtl/sparse_xlate_pkg.sv
package sparse_xlate_pkg;

  localparam int NSPACE = 4;
  localparam int CPU_AW = 40;
  localparam int PCI_AW = 32;
  localparam int QW_LSB = 7;

  typedef enum logic [2:0] {
    SPC_NONE = 3'd0,
    SPC_MEMA = 3'd1,
    SPC_MEMB = 3'd2,
    SPC_MEMC = 3'd3,
    SPC_IO   = 3'd4
  } space_e;

  // PCI offset width of each window
  function automatic int space_ofs_w(input int idx);
    case (idx)
      0:       return 29;
      1:       return 27;
      2:       return 26;
      default: return 25;
    endcase
  endfunction

  function automatic logic [CPU_AW-1:0] space_base(input int idx);
    case (idx)
      0:       return 40'h80_0000_0000;
      1:       return 40'h84_0000_0000;
      2:       return 40'h85_0000_0000;
      default: return 40'h85_8000_0000;
    endcase
  endfunction

  function automatic bit space_uses_ext(input int idx);
    return (idx != 3);
  endfunction

  // lowest PCI bit that any window takes from the extension register
  function automatic int ext_lsb();
    int m;
    m = PCI_AW;
    for (int i = 0; i < NSPACE; i++)
      if (space_uses_ext(i) && space_ofs_w(i) < m) m = space_ofs_w(i);
    return m;
  endfunction

  localparam int EXT_LSB = ext_lsb();
  localparam int EXT_W   = PCI_AW - EXT_LSB;

endpackage

// File: rtl/sparse_ext_reg.sv
module sparse_ext_reg
  import sparse_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [EXT_W-1:0] wdata,
  output logic [EXT_W-1:0] q
);

  logic [EXT_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/sparse_lane_enc.sv
module sparse_lane_enc (
  input  logic [1:0] size_code,
  input  logic [1:0] lane,
  output logic [3:0] be_n,
  output logic       overrun
);

  logic [2:0] last_lane;
  logic [7:0] span;

  always_comb begin
    last_lane = {1'b0, lane} + {1'b0, size_code};
    overrun   = last_lane[2];
    span      = (8'd2 << size_code) - 8'd1;
    span      = span << lane;
    be_n      = overrun ? 4'hF : ~span[3:0];
  end

endmodule

// File: rtl/sparse_space_dec.sv
module sparse_space_dec
  import sparse_xlate_pkg::*;
(
  input  logic [CPU_AW-1:QW_LSB] qw_addr,
  input  logic [EXT_W-1:0]       ext,
  output logic                   hit,
  output space_e                 space,
  output logic [PCI_AW-1:0]      pci_addr
);

  logic [NSPACE-1:0] win_hit;
  logic [PCI_AW-1:0] win_addr [NSPACE];

  for (genvar g = 0; g < NSPACE; g++) begin : g_win
    localparam int OW = space_ofs_w(g);
    localparam int HI = OW + 5;
    localparam logic [CPU_AW-1:0] BASE = space_base(g);
    logic [PCI_AW-OW-1:0] upper;

    assign win_hit[g] = (qw_addr[CPU_AW-1:HI] == BASE[CPU_AW-1:HI]);

    if (space_uses_ext(g)) begin : g_ext
      assign upper = ext[EXT_W-1:OW-EXT_LSB];
    end else begin : g_zero
      assign upper = '0;
    end

    assign win_addr[g] = {upper, qw_addr[OW+4:QW_LSB], 2'b00};
  end

  always_comb begin
    hit      = 1'b0;
    space    = SPC_NONE;
    pci_addr = '0;
    for (int i = NSPACE - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        hit      = 1'b1;
        space    = space_e'(3'(i + 1));
        pci_addr = win_addr[i];
      end
    end
  end

endmodule

// File: rtl/sparse_xlate_top.sv
module sparse_xlate_top
  import sparse_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [39:0]       req_addr,
  input  logic              csr_we,
  input  logic [5:0]        csr_wdata,
  output logic              res_valid,
  output logic              res_write,
  output logic [31:0]       res_addr,
  output logic [3:0]        res_be,
  output logic [2:0]        res_space,
  output logic              res_err
);

  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [EXT_W-1:0] ext_q;

  sparse_ext_reg u_ext (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (csr_we),
    .wdata (csr_wdata),
    .q     (ext_q)
  );

  logic              dec_hit;
  space_e            dec_space;
  logic [PCI_AW-1:0] dec_addr;

  sparse_space_dec u_dec (
    .qw_addr  (req_addr[CPU_AW-1:QW_LSB]),
    .ext      (ext_q),
    .hit      (dec_hit),
    .space    (dec_space),
    .pci_addr (dec_addr)
  );

  logic [3:0] enc_be;
  logic       enc_overrun;

  sparse_lane_enc u_enc (
    .size_code (req_addr[4:3]),
    .lane      (req_addr[6:5]),
    .be_n      (enc_be),
    .overrun   (enc_overrun)
  );

  logic              err_nxt;
  logic [PCI_AW-1:0] addr_nxt;
  logic [3:0]        be_nxt;

  always_comb begin
    err_nxt  = !dec_hit || (req_addr[2:0] != 3'b000) || enc_overrun;
    addr_nxt = err_nxt ? '0    : dec_addr;
    be_nxt   = err_nxt ? 4'hF  : enc_be;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) res_valid <= 1'b0;
    else             res_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_write <= 1'b0;
      res_addr  <= '0;
      res_be    <= 4'hF;
      res_space <= SPC_NONE;
      res_err   <= 1'b0;
    end else if (req_valid) begin
      res_write <= req_write;
      res_addr  <= addr_nxt;
      res_be    <= be_nxt;
      res_space <= dec_space;
      res_err   <= err_nxt;
    end
  end

endmodule

// File: rtl/sparse_xlate_chk.sv
module sparse_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        res_valid,
  input logic        res_err,
  input logic [3:0]  res_be,
  input logic [31:0] res_addr,
  input logic [2:0]  res_space
);

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);                                         // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);                                       // R1
  AST_ERR_BE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_be == 4'hF && res_addr == 32'd0)); // R5
  AST_NONE_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_space == 3'd0) |-> res_err);                    // R7
  AST_OK_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (res_addr[1:0] == 2'b00));            // R8
  AST_OK_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (res_be != 4'hF && res_space <= 3'd4)); // R4

endmodule

bind sparse_xlate_top sparse_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .res_valid (res_valid),
  .res_err   (res_err),
  .res_be    (res_be),
  .res_addr  (res_addr),
  .res_space (res_space)
);

// File: tb/tb_sparse_xlate_top.sv
`timescale 1ns/1ps
module tb_sparse_xlate_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, csr_we;
  logic [39:0] req_addr;
  logic [5:0]  csr_wdata;
  logic        res_valid, res_write, res_err;
  logic [31:0] res_addr;
  logic [3:0]  res_be;
  logic [2:0]  res_space;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] ext_m = 32'd0;

  always #2 clk = ~clk;

  sparse_xlate_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .res_valid(res_valid), .res_write(res_write), .res_addr(res_addr),
    .res_be(res_be), .res_space(res_space), .res_err(res_err));

  localparam logic [39:0] BA = 40'h80_0000_0000;
  localparam logic [39:0] BB = 40'h84_0000_0000;
  localparam logic [39:0] BC = 40'h85_0000_0000;
  localparam logic [39:0] BI = 40'h85_8000_0000;

  function automatic logic [39:0] mk(logic [39:0] base, logic [39:0] qw,
                                     int lane, int len);
    return base + (qw << 7) + 40'(lane << 5) + 40'(len << 3);
  endfunction

  task automatic model(input logic [39:0] a, input logic [31:0] extv,
                       output logic [31:0] ea, output logic [3:0] ebe,
                       output logic [2:0] esp, output logic eerr);
    logic [63:0] base, off, lowmask;
    int w, nb, ln;
    bit useext, overrun;
    useext = 1; w = 0; base = 0; esp = 0;
    if (a >= BA && a < BB)                        begin esp = 1; base = BA; w = 29; end
    else if (a >= BB && a < BC)                   begin esp = 2; base = BB; w = 27; end
    else if (a >= BC && a < BI)                   begin esp = 3; base = BC; w = 26; end
    else if (a >= BI && a < 40'h85_C000_0000)     begin esp = 4; base = BI; w = 25; useext = 0; end
    nb = int'(a[4:3]) + 1;
    ln = int'(a[6:5]);
    overrun = (ln + nb) > 4;
    for (int b = 0; b < 4; b++) ebe[b] = !(b >= ln && b < ln + nb);
    eerr = (esp == 0) || (a[2:0] != 0) || overrun;
    if (eerr) begin
      ea = 0; ebe = 4'hF;
    end else begin
      off = ({24'd0, a} - base) >> 5;
      lowmask = (64'd1 << w) - 1;
      ea = 32'(((useext ? {32'd0, extv} : 64'd0) & ~lowmask) | (off & lowmask & ~64'd3));
    end
  endtask

  task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
    bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // called at a falling edge; compares at the next falling edge
  task automatic step(bit v, bit wr, logic [39:0] a, bit we, logic [5:0] wd, string tag);
    logic [31:0] ea; logic [3:0] ebe; logic [2:0] esp; logic eerr;
    req_valid = v; req_write = wr; req_addr = a; csr_we = we; csr_wdata = wd;
    model(a, ext_m, ea, ebe, esp, eerr);
    if (we) ext_m = {wd, 26'd0};
    @(negedge clk);
    total++;
    if (!v) begin
      if (res_valid !== 1'b0) fail_line(tag, "valid", 64'(res_valid), 0);
    end else if (res_valid !== 1'b1 || res_write !== wr || res_addr !== ea ||
                 res_be !== ebe || res_space !== esp || res_err !== eerr) begin
      bad++;
      $display("FAIL %s actual v=%0d w=%0d a=%h be=%b sp=%0d e=%0d expected v=1 w=%0d a=%h be=%b sp=%0d e=%0d",
               tag, res_valid, res_write, res_addr, res_be, res_space, res_err,
               wr, ea, ebe, esp, eerr);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; csr_we = 0; csr_wdata = 0;
    repeat (3) @(negedge clk);
    total++;
    if (res_valid !== 1'b0) fail_line("R1", "reset valid", 64'(res_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset value of extension register is zero
    step(1, 0, mk(BA, 40'h0ABCDE, 0, 0), 0, 0, "R9");
    // R10 write and same-cycle request: old value used, new value next
    step(1, 1, mk(BA, 40'h0ABCDE, 0, 0), 1, 6'b101011, "R10");
    step(1, 1, mk(BA, 40'h0ABCDE, 0, 0), 0, 0, "R10");
    // R3 one-byte lanes
    for (int l = 0; l < 4; l++) step(1, 0, mk(BA, 40'h123456, l, 0), 0, 0, "R3");
    // R4 word, tribyte, longword
    for (int l = 0; l < 3; l++) step(1, 1, mk(BA, 40'h00F00F, l, 1), 0, 0, "R4");
    for (int l = 0; l < 2; l++) step(1, 0, mk(BA, 40'h00F00F, l, 2), 0, 0, "R4");
    step(1, 0, mk(BA, 40'h7FFFFFF, 0, 3), 0, 0, "R4");
    // R5 overrunning combinations
    step(1, 0, mk(BB, 40'h1234, 3, 1), 0, 0, "R5");
    step(1, 0, mk(BB, 40'h1234, 2, 2), 0, 0, "R5");
    step(1, 0, mk(BB, 40'h1234, 1, 3), 0, 0, "R5");
    // R6 low bits set
    step(1, 0, mk(BA, 40'h10, 0, 3) + 40'd4, 0, 0, "R6");
    step(1, 0, mk(BC, 40'h10, 0, 0) + 40'd1, 0, 0, "R6");
    // R2 / R8 each window, edges of range
    step(1, 0, mk(BB, 40'h1FFFFFF, 0, 3), 0, 0, "R2");
    step(1, 1, mk(BC, 40'h0FFFFFF, 1, 1), 0, 0, "R2");
    step(1, 0, mk(BI, 40'h0000001, 2, 0), 0, 0, "R8");
    step(1, 0, mk(BI, 40'h07FFFFF, 0, 3), 0, 0, "R9");
    step(1, 0, 40'h83_FFFF_FFE0, 0, 0, "R2");
    // R7 unmapped or bit 39 clear
    step(1, 0, 40'h85_C000_0000, 0, 0, "R7");
    step(1, 0, 40'h86_0000_0018, 0, 0, "R7");
    step(1, 0, 40'h04_0000_0000, 0, 0, "R7");
    // R1 idle cycles produce no result
    step(0, 0, mk(BA, 40'h5, 0, 0), 0, 0, "R1");
    step(0, 1, 40'd0, 1, 6'b010101, "R1");
    // R9 new extension value in each memory window and the I/O window
    step(1, 0, mk(BB, 40'h2, 0, 3), 0, 0, "R9");
    step(1, 0, mk(BC, 40'h3, 0, 3), 0, 0, "R9");
    step(1, 0, mk(BI, 40'h3, 0, 3), 0, 0, "R9");
    step(0, 0, 40'd0, 0, 0, "R1");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule